// File: doc/BRIEF.md
# Hybrid Strict-Priority / Weighted Round-Robin Egress Scheduler

This block arbitrates the egress of one QoS channel that owns eight transmit queues. From per-queue backlog flags it picks, every cycle, the queue to serve next. A 3-bit mode selects pure strict priority, pure weighted round robin over all eight queues, or a split. In a split, the lowest-numbered queues are strict and always win. The remaining queues share the leftover service in proportion to programmed weights.

Software programs the block through three write ports. The weight command word carries a strobe, a channel number, a weight index and a 16-bit weight, and a done flag answers it. The mode word packs one 3-bit mode per channel into 4-bit slots, eight channels per word. The close word holds one disable bit per queue, with four channels per word. The `CHAN_ID` parameter says which channel this instance decodes. The downstream logic pulses `advance` when it takes the offered grant, and each taken grant spends credit from the granted weighted queue. By default a grant costs one unit. With `CREDIT_BYTES` set, it costs `pkt_len` units.

Top module: `egress_sched`

## Requirements
- R1: After reset the mode is pure strict priority, all eight weights are 1, no queue is closed, `cmd_done` is 0, and with no backlog `grant_valid` is 0.
- R2: The mode is bits [4*(CHAN_ID mod 8)+2 : 4*(CHAN_ID mod 8)] of `mode_word`, loaded when `mode_wr` is high. Mode 0 makes all eight queues weighted. Mode 1 makes all eight strict. A mode m from 2 to 7 makes queues 0 to m-2 strict and the other 9-m queues weighted.
- R3: When any open, backlogged strict queue exists, the grant goes to the lowest-numbered such queue, ahead of every weighted queue.
- R4: A write to `cmd_word` is accepted only when bit 31 is 1 and bits 23:19 equal CHAN_ID. An accepted write stores bits 15:0 as the weight of weight index bits 18:16. Any other write changes no weight.
- R5: `cmd_done` is 1 from the cycle after an accepted command write. It is 0 from the cycle after a write that is not accepted. It holds between writes.
- R6: Weight index 0 belongs to the first weighted queue, index 1 to the next, and so on. A weighted queue is granted as many times in a row as its credit allows. The turn then passes upward to the next eligible weighted queue, wrapping from queue 7 to queue 0.
- R7: The credits of all weighted queues reload from their weights when no open, backlogged weighted queue has credit left. A stored weight of 0 acts as 1.
- R8: The close bits are bits [8*(CHAN_ID mod 4)+7 : 8*(CHAN_ID mod 4)] of `close_word`, loaded when `close_wr` is high, where bit q closes queue q. A closed queue is never granted, and skipping it costs no cycle: a grant is offered on every cycle in which some open queue is backlogged.
- R9: When no open queue is backlogged, `grant_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the weight command word |
| cmd_word | input | 32 | Weight command: strobe 31, channel 23:19, index 18:16, weight 15:0 |
| cmd_done | output | 1 | Weight command completion flag |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_word | input | 32 | Packed per-channel modes, 4-bit slots |
| close_wr | input | 1 | Write strobe for the close word |
| close_word | input | 32 | Packed per-queue disable bits, 8 per channel |
| backlog | input | 8 | Per-queue backlog flags |
| advance | input | 1 | The offered grant is taken this cycle |
| pkt_len | input | 16 | Cost of the taken grant in byte-credit builds |
| grant_valid | output | 1 | A queue is offered |
| grant_idx | output | 3 | Index of the offered queue |

## Verification
The hardest state to reach is a credit reload that coincides with a wrap of the round-robin turn while closed or strict queues sit among the weighted ones. The first queue served after the reload must come from the low end of the ring and not from the pointer's raw position. The bench reaches this state by holding `advance` high for whole rounds over unequal weights. It does so with queues closed in the middle of the ring, and with mixed modes in which the weight index is offset from the queue number. A scoreboard compares every taken grant against the expected sequence, which is worked out per round from the weights.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int NUM_Q    = 8;
    localparam int QIDX_W   = $clog2(NUM_Q);
    localparam int WT_W     = 16;
    localparam int MODE_W   = 3;
    localparam int CH_W     = 5;
    localparam int WORD_W   = 32;

    // command word field positions
    localparam int CMD_STB     = 31;
    localparam int CMD_CH_LSB  = 19;
    localparam int CMD_IDX_LSB = 16;

    localparam logic [MODE_W-1:0] MODE_ALL_WRR    = 3'd0;
    localparam logic [MODE_W-1:0] MODE_ALL_STRICT = 3'd1;

    typedef logic [NUM_Q-1:0][WT_W-1:0] wt_arr_t;

    typedef struct packed {
        logic              valid;
        logic [QIDX_W-1:0] idx;
        logic              is_wrr;
    } grant_t;

    function automatic logic [QIDX_W:0] strict_count(logic [MODE_W-1:0] m);
        case (m)
            MODE_ALL_WRR:    return '0;
            MODE_ALL_STRICT: return (QIDX_W+1)'(NUM_Q);
            default:         return {1'b0, m} - 1'b1;
        endcase
    endfunction

    function automatic logic [NUM_Q-1:0] strict_mask(logic [MODE_W-1:0] m);
        logic [NUM_Q:0] t;
        t = ((NUM_Q+1)'(1) << strict_count(m)) - (NUM_Q+1)'(1);
        return t[NUM_Q-1:0];
    endfunction

    function automatic logic [QIDX_W-1:0] lowest(logic [NUM_Q-1:0] v);
        logic [QIDX_W-1:0] r;
        r = '0;
        for (int i = NUM_Q-1; i >= 0; i--)
            if (v[i]) r = QIDX_W'(i);
        return r;
    endfunction

    function automatic logic [QIDX_W-1:0] rot_pick(logic [NUM_Q-1:0] v,
                                                   logic [QIDX_W-1:0] start);
        logic [QIDX_W-1:0] r;
        logic [QIDX_W-1:0] j;
        logic found;
        r = start;
        found = 1'b0;
        for (int i = 0; i < NUM_Q; i++) begin
            j = start + QIDX_W'(i);
            if (!found && v[j]) begin
                r = j;
                found = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [WT_W-1:0] wt_or_one(logic [WT_W-1:0] w);
        return (w == '0) ? WT_W'(1) : w;
    endfunction
endpackage

// File: rtl/sched_cfg.sv
module sched_cfg
    import sched_pkg::*;
#(
    parameter int CHAN_ID = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_wr,
    input  logic [WORD_W-1:0]   cmd_word,
    input  logic                mode_wr,
    input  logic [WORD_W-1:0]   mode_word,
    input  logic                close_wr,
    input  logic [WORD_W-1:0]   close_word,
    output logic [MODE_W-1:0]   mode,
    output logic [NUM_Q-1:0]    closed,
    output wt_arr_t             weights,
    output logic                cmd_done
);
    localparam int MODE_LSB  = 4 * (CHAN_ID % 8);
    localparam int CLOSE_LSB = NUM_Q * (CHAN_ID % 4);

    logic              hit;
    logic [QIDX_W-1:0] widx;
    logic [WT_W-1:0]   wval;
    logic              unused_bits;

    assign hit  = cmd_word[CMD_STB] &&
                  (cmd_word[CMD_CH_LSB +: CH_W] == CH_W'(CHAN_ID));
    assign widx = cmd_word[CMD_IDX_LSB +: QIDX_W];
    assign wval = cmd_word[WT_W-1:0];
    assign unused_bits = ^{cmd_word, mode_word, close_word};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_ALL_STRICT;
            closed   <= '0;
            weights  <= {NUM_Q{WT_W'(1)}};
            cmd_done <= 1'b0;
        end else begin
            if (mode_wr)
                mode <= mode_word[MODE_LSB +: MODE_W];
            if (close_wr)
                closed <= close_word[CLOSE_LSB +: NUM_Q];
            if (cmd_wr) begin
                cmd_done <= hit;
                if (hit)
                    weights[widx] <= wval;
            end
        end
    end
endmodule

// File: rtl/sched_credit.sv
module sched_credit
    import sched_pkg::*;
#(
    parameter bit CREDIT_BYTES = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_Q-1:0]  active,
    input  logic [NUM_Q-1:0]  wrr_mask,
    input  logic [QIDX_W:0]   nstrict,
    input  wt_arr_t           weights,
    input  logic              take,
    input  logic [QIDX_W-1:0] take_idx,
    input  logic [WT_W-1:0]   pkt_len,
    output logic              pick_valid,
    output logic [QIDX_W-1:0] pick_idx
);
    wt_arr_t           credit;
    wt_arr_t           eff;
    wt_arr_t           load_w;
    logic [QIDX_W-1:0] rr_ptr;
    logic [NUM_Q-1:0]  wrr_act;
    logic [NUM_Q-1:0]  has_cr;
    logic [NUM_Q-1:0]  elig;
    logic              reload;
    logic [WT_W-1:0]   cost;
    logic [WT_W-1:0]   left;

    assign cost = CREDIT_BYTES ? pkt_len : WT_W'(1);

    always_comb begin
        wrr_act = active & wrr_mask;
        for (int q = 0; q < NUM_Q; q++) begin
            load_w[q] = wt_or_one(weights[QIDX_W'(q) - nstrict[QIDX_W-1:0]]);
            has_cr[q] = (credit[q] != '0);
        end
        reload = (|wrr_act) && !(|(wrr_act & has_cr));
        for (int q = 0; q < NUM_Q; q++) begin
            eff[q]  = reload ? load_w[q] : credit[q];
            elig[q] = wrr_act[q] && (eff[q] != '0);
        end
        pick_valid = |elig;
        pick_idx   = rot_pick(elig, rr_ptr);
        left       = (eff[take_idx] > cost) ? eff[take_idx] - cost : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credit <= '0;
            rr_ptr <= '0;
        end else if (take) begin
            credit           <= eff;
            credit[take_idx] <= left;
            rr_ptr           <= (left == '0) ? take_idx + 1'b1 : take_idx;
        end
    end
endmodule

// File: rtl/egress_sched.sv
module egress_sched
    import sched_pkg::*;
#(
    parameter int CHAN_ID      = 5,
    parameter bit CREDIT_BYTES = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_word,
    output logic        cmd_done,
    input  logic        mode_wr,
    input  logic [31:0] mode_word,
    input  logic        close_wr,
    input  logic [31:0] close_word,
    input  logic [7:0]  backlog,
    input  logic        advance,
    input  logic [15:0] pkt_len,
    output logic        grant_valid,
    output logic [2:0]  grant_idx
);
    logic [MODE_W-1:0] mode;
    logic [NUM_Q-1:0]  closed;
    wt_arr_t           weights;
    logic [NUM_Q-1:0]  active;
    logic [NUM_Q-1:0]  smask;
    logic [NUM_Q-1:0]  s_act;
    logic              pick_valid;
    logic [QIDX_W-1:0] pick_idx;
    grant_t            gnt;

    sched_cfg #(.CHAN_ID(CHAN_ID)) cfg_i (
        .clk(clk), .rst(rst),
        .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .mode_wr(mode_wr), .mode_word(mode_word),
        .close_wr(close_wr), .close_word(close_word),
        .mode(mode), .closed(closed), .weights(weights),
        .cmd_done(cmd_done)
    );

    assign active = backlog & ~closed;
    assign smask  = strict_mask(mode);
    assign s_act  = active & smask;

    sched_credit #(.CREDIT_BYTES(CREDIT_BYTES)) credit_i (
        .clk(clk), .rst(rst),
        .active(active), .wrr_mask(~smask),
        .nstrict(strict_count(mode)), .weights(weights),
        .take(advance && gnt.valid && gnt.is_wrr), .take_idx(gnt.idx),
        .pkt_len(pkt_len),
        .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    always_comb begin
        if (|s_act) begin
            gnt.valid  = 1'b1;
            gnt.idx    = lowest(s_act);
            gnt.is_wrr = 1'b0;
        end else begin
            gnt.valid  = pick_valid;
            gnt.idx    = pick_idx;
            gnt.is_wrr = 1'b1;
        end
    end

    assign grant_valid = gnt.valid;
    assign grant_idx   = gnt.idx;
endmodule

// File: rtl/egress_sched_chk.sv
module egress_sched_chk #(
    parameter int CHAN_ID = 5
) (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  backlog,
    input logic [7:0]  closed,
    input logic [7:0]  smask,
    input logic        grant_valid,
    input logic [2:0]  grant_idx,
    input logic        cmd_wr,
    input logic [31:0] cmd_word,
    input logic        cmd_done
);
    logic [7:0] act;
    assign act = backlog & ~closed;

    // R9
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (act == 8'h00) |-> !grant_valid);

    // R8
    grant_is_open_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (backlog[grant_idx] && !closed[grant_idx]));

    // R8
    no_lost_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (act != 8'h00) |-> grant_valid);

    // R3
    strict_first_chk: assert property (@(posedge clk) disable iff (rst)
        ((act & smask) != 8'h00) |->
            (smask[grant_idx] && ((act & smask & ((8'h01 << grant_idx) - 8'h01)) == 8'h00)));

    // R5
    done_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_word[31] && (cmd_word[23:19] == 5'(CHAN_ID))) |=> cmd_done);

    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !(cmd_word[31] && (cmd_word[23:19] == 5'(CHAN_ID)))) |=> !cmd_done);
endmodule

bind egress_sched egress_sched_chk #(.CHAN_ID(CHAN_ID)) chk_i (
    .clk(clk), .rst(rst), .backlog(backlog), .closed(closed), .smask(smask),
    .grant_valid(grant_valid), .grant_idx(grant_idx),
    .cmd_wr(cmd_wr), .cmd_word(cmd_word), .cmd_done(cmd_done)
);

// File: tb/egress_sched_test.sv
`timescale 1ns/1ps
module egress_sched_test;
    localparam int CH = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_wr, mode_wr, close_wr, advance;
    logic [31:0] cmd_word, mode_word, close_word;
    logic        cmd_done, grant_valid;
    logic [7:0]  backlog;
    logic [15:0] pkt_len;
    logic [2:0]  grant_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    egress_sched #(.CHAN_ID(CH)) uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .cmd_done(cmd_done), .mode_wr(mode_wr), .mode_word(mode_word),
        .close_wr(close_wr), .close_word(close_word), .backlog(backlog),
        .advance(advance), .pkt_len(pkt_len),
        .grant_valid(grant_valid), .grant_idx(grant_idx)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: compare each taken grant with the scoreboard
    always @(negedge clk) begin
        if (advance && !rst) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underrun", 1, 0);
            end else begin
                automatic int    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, grant_valid ? int'(grant_idx) : -1, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_seq(string tag, int s[]);
        foreach (s[i]) begin
            exp_q.push_back(s[i]);
            tag_q.push_back(tag);
        end
    endtask

    task automatic serve(int n);
        advance = 1'b1;
        repeat (n) tick();
        advance = 1'b0;
        check("scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1; cmd_wr = 0; mode_wr = 0; close_wr = 0; advance = 0;
        cmd_word = 0; mode_word = 0; close_word = 0; backlog = 0; pkt_len = 1;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic wr_weight(bit stb, int ch, int idx, int val);
        cmd_word = {stb, 1'b0, 6'b0, 5'(ch), 3'(idx), 16'(val)};
        cmd_wr = 1'b1;
        tick();
        cmd_wr = 1'b0;
    endtask

    task automatic set_mode(int m);
        mode_word = 32'h7777_7777;
        mode_word[4*(CH%8) +: 3] = 3'(m);
        mode_wr = 1'b1;
        tick();
        mode_wr = 1'b0;
    endtask

    task automatic set_close(int msk);
        close_word = 32'hFFFF_FFFF;
        close_word[8*(CH%4) +: 8] = 8'(msk);
        close_wr = 1'b1;
        tick();
        close_wr = 1'b0;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 no grant without backlog", grant_valid, 0);
        check("R1 cmd_done after reset", cmd_done, 0);
        tick();
        backlog = 8'hA4;
        @(negedge clk);
        check("R1 default strict grant", grant_idx, 2);
        check("R3 lowest strict wins", grant_valid, 1);
        tick();
        set_close(8'h04);
        @(negedge clk);
        check("R8 closed queue skipped", grant_idx, 5);
        tick();
        set_close(8'h00);
        @(negedge clk);
        check("R8 reopened queue", grant_idx, 2);
        tick();
        backlog = 8'h04;
        set_close(8'h04);
        @(negedge clk);
        check("R9 only closed backlog", grant_valid, 0);

        // R6 R7: full WRR with unequal weights
        do_reset();
        set_mode(0);
        wr_weight(1, CH, 0, 2);
        @(negedge clk);
        check("R5 done after accepted write", cmd_done, 1);
        tick();
        wr_weight(1, CH, 1, 1);
        wr_weight(1, CH, 2, 3);
        backlog = 8'h07;
        expect_seq("R6 wrr8 weights 2/1/3", '{0,0,1,2,2,2,0,0,1,2,2,2});
        serve(12);

        // R2 R3: mode 3, queues 0..1 strict, weight index offset by two
        do_reset();
        set_mode(3);
        wr_weight(1, CH, 1, 2);
        wr_weight(1, CH, 2, 1);
        backlog = 8'h1A;
        expect_seq("R3 strict beats wrr", '{1,1,1});
        serve(3);
        backlog = 8'h18;
        expect_seq("R6 weight index offset", '{3,3,4,3,3,4});
        serve(6);

        // R7: zero weight acts as one
        do_reset();
        set_mode(0);
        wr_weight(1, CH, 0, 0);
        wr_weight(1, CH, 1, 2);
        backlog = 8'h03;
        expect_seq("R7 zero weight as one", '{0,1,1,0,1,1});
        serve(6);

        // R8: closed queues inside the ring cost no cycle
        do_reset();
        set_mode(0);
        set_close(8'h06);
        backlog = 8'hFF;
        expect_seq("R8 skip without idle", '{0,3,4,5,6,7,0,3});
        serve(8);

        // R4 R5: ignored commands
        do_reset();
        set_mode(0);
        wr_weight(1, CH, 1, 1);
        @(negedge clk);
        check("R5 done set", cmd_done, 1);
        tick();
        wr_weight(1, CH - 1, 0, 5);
        @(negedge clk);
        check("R4 wrong channel clears done", cmd_done, 0);
        tick();
        wr_weight(0, CH, 0, 5);
        @(negedge clk);
        check("R4 missing strobe keeps done low", cmd_done, 0);
        tick();
        backlog = 8'h03;
        expect_seq("R4 ignored weight unchanged", '{0,1,0,1});
        serve(4);

        // R2: modes 7 and 2
        do_reset();
        set_mode(7);
        backlog = 8'hE0;
        expect_seq("R2 mode7 queue5 strict", '{5,5});
        serve(2);
        backlog = 8'hC0;
        expect_seq("R2 mode7 two wrr queues", '{6,7,6,7});
        serve(4);
        set_mode(2);
        backlog = 8'h03;
        expect_seq("R2 mode2 queue0 strict", '{0,0});
        serve(2);
        backlog = 8'h06;
        expect_seq("R2 mode2 queue1 is wrr", '{1,2,1,2});
        serve(4);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule